// File: doc/BRIEF.md
# Streaming Sobel Edge Detector

This block turns a raster stream of 8-bit greyscale pixels, one per clock, into a one-bit edge map at the same rate. Two on-chip line stores keep the two most recent complete rows. A 3x3 register window is built from those two rows and the incoming pixel. Horizontal and vertical Sobel gradients are computed in parallel using only shifts and adds. The sum of their absolute values is compared with a programmable threshold.

The pixel that starts a frame carries a start-of-frame flag, and the last pixel of each row carries an end-of-line flag. Each result is tagged with the position of the newest pixel in its window, so the window's centre lies one column to the left and one row above that position. A window is complete only when it has two earlier columns and two earlier rows. Results for positions without a complete window are forced to "no edge". The threshold is captured with the frame's first pixel and holds for the whole frame. Stalls are handled with the valid input: cycles without a valid pixel leave all state untouched and produce no output.

Top module: `sobel_edge_stream`

## Requirements
- R1: Every accepted pixel (in_valid high at a rising edge) produces exactly one result. out_valid is high exactly three cycles after in_valid was sampled: the result is registered on the second rising edge after the accepting edge. Throughput is one pixel per clock.
- R2: A pixel with in_sof high has position (0,0). After a pixel with in_eol high, the next pixel has x=0 and y incremented. Otherwise x increments by one. out_x and out_y report the position of the pixel whose result is being shown.
- R3: For a result at (x,y), with window rows y-2..y and columns x-2..x, gx = (top + 2*middle + bottom of column x) minus (the same weighted sum of column x-2).
- R4: gy = (left + 2*centre + right of row y) minus (the same weighted sum of row y-2).
- R5: The magnitude is |gx|+|gy|. It never exceeds 2040 and is computed without wrap.
- R6: out_edge is 1 exactly when the magnitude is strictly greater than the frame threshold. A magnitude equal to the threshold gives 0.
- R7: When x<2 or y<2, out_edge is 0 whatever the pixel values, including stale line-store content from a previous frame.
- R8: The threshold is sampled from in_thr on the start-of-frame pixel. Changes of in_thr during the rest of the frame have no effect on that frame's results.
- R9: While in_valid is low, no result is produced and the window and line stores hold their contents. Idle gaps anywhere in a frame leave every result unchanged.
- R10: Rows of any length from 3 up to MAX_W pixels are supported, and the row length may change from frame to frame.
- R11: After reset, out_valid and out_edge are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel on in_pix is valid this cycle |
| in_sof | input | 1 | This pixel is the first of a frame |
| in_eol | input | 1 | This pixel is the last of its row |
| in_pix | input | 8 | Greyscale pixel value |
| in_thr | input | 11 | Edge threshold, sampled with the start-of-frame pixel |
| out_valid | output | 1 | A result is present |
| out_edge | output | 1 | Edge decision for the reported position |
| out_x | output | $clog2(MAX_W) | Column of the newest pixel of the window |
| out_y | output | $clog2(MAX_H) | Row of the newest pixel of the window |

## Verification
A corrupted line store or a window that shifts on an idle cycle shows up as wrong edge bits. These appear from the third row of a frame onward, three cycles after the offending pixel, and the errors are confined to the columns that read the bad entry. A position counter that slips appears at once as a coordinate mismatch on out_x or out_y. The same slip also moves the border mask onto the wrong pixels. Ramps whose magnitude sits exactly on the threshold and a pattern with full-scale steps expose the weighting, the sign handling and the compare direction. A frame whose threshold input drops after its first pixel exposes a threshold that is not frozen: the extra edges appear in that frame.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

    localparam int PIX_W    = 8;
    localparam int GRAD_W   = PIX_W + 3;
    localparam int MAG_W    = PIX_W + 3;
    localparam int GRAD_MAX = 4 * ((1 << PIX_W) - 1);

    typedef logic [PIX_W-1:0]          pix_t;
    typedef logic signed [GRAD_W-1:0]  grad_t;
    typedef logic [MAG_W-1:0]          mag_t;
    // [row][col]; row 0 is the oldest line, col 0 the oldest column
    typedef logic [2:0][2:0][PIX_W-1:0] win_t;

    function automatic grad_t widen(input pix_t p);
        return grad_t'({{(GRAD_W-PIX_W){1'b0}}, p});
    endfunction

    // a + 2b + c with the factor two done as a shift
    function automatic grad_t weigh121(input pix_t a, input pix_t b, input pix_t c);
        return widen(a) + (widen(b) <<< 1) + widen(c);
    endfunction

    function automatic mag_t magnitude(input grad_t g);
        grad_t n;
        n = g[GRAD_W-1] ? -g : g;
        return mag_t'(n);
    endfunction

endpackage

// File: rtl/sobel_line_store.sv
module sobel_line_store
    import sobel_pkg::*;
#(
    parameter int MAX_W = 640,
    parameter int MAX_H = 480
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_sof,
    input  logic                     in_eol,
    input  pix_t                     in_pix,
    output pix_t                     tap_top,
    output pix_t                     tap_mid,
    output logic [$clog2(MAX_W)-1:0] cur_x,
    output logic [$clog2(MAX_H)-1:0] cur_y
);
    localparam int X_W = $clog2(MAX_W);
    localparam int Y_W = $clog2(MAX_H);
    localparam logic [X_W:0]   X_LIM = (X_W+1)'(MAX_W);
    localparam logic [X_W-1:0] X_ONE = 1;
    localparam logic [Y_W-1:0] Y_ONE = 1;

    typedef struct packed {
        logic [X_W-1:0] x;
        logic [Y_W-1:0] y;
    } pos_t;

    pos_t pos_d, pos_q;
    logic in_range;

    // previous row and the row before it, indexed by column
    pix_t near_mem [MAX_W];
    pix_t far_mem  [MAX_W];

    always_comb begin
        cur_x    = in_sof ? '0 : pos_q.x;
        cur_y    = in_sof ? '0 : pos_q.y;
        in_range = ({1'b0, cur_x} < X_LIM);
        pos_d    = pos_q;
        if (in_valid) begin
            if (in_eol) begin
                pos_d.x = '0;
                pos_d.y = cur_y + Y_ONE;
            end else begin
                pos_d.x = cur_x + X_ONE;
                pos_d.y = cur_y;
            end
        end
        tap_mid = in_range ? near_mem[cur_x] : '0;
        tap_top = in_range ? far_mem[cur_x]  : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    // an entry is replaced the moment its last consumer has read it
    always_ff @(posedge clk) begin
        if (in_valid && in_range) begin
            near_mem[cur_x] <= in_pix;
            far_mem[cur_x]  <= near_mem[cur_x];
        end
    end

    assert_row_fits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> in_range);

    assert_column_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_eol && !in_sof) |=> (in_sof || (pos_q.x == $past(pos_q.x) + X_ONE)));

endmodule

// File: rtl/sobel_window.sv
module sobel_window
    import sobel_pkg::*;
#(
    parameter int MAX_W = 640,
    parameter int MAX_H = 480
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_sof,
    input  mag_t                     in_thr,
    input  pix_t                     tap_top,
    input  pix_t                     tap_mid,
    input  pix_t                     tap_bot,
    input  logic [$clog2(MAX_W)-1:0] pos_x,
    input  logic [$clog2(MAX_H)-1:0] pos_y,
    output logic                     s1_valid,
    output logic [$clog2(MAX_W)-1:0] s1_x,
    output logic [$clog2(MAX_H)-1:0] s1_y,
    output logic                     s1_border,
    output mag_t                     s1_thr,
    output win_t                     s1_win
);
    localparam int X_W = $clog2(MAX_W);
    localparam int Y_W = $clog2(MAX_H);
    localparam logic [X_W-1:0] X_TWO = 2;
    localparam logic [Y_W-1:0] Y_TWO = 2;

    typedef struct packed {
        logic           valid;
        logic [X_W-1:0] x;
        logic [Y_W-1:0] y;
        logic           border;
        mag_t           thr;
        mag_t           frame_thr;
        win_t           win;
    } win_st_t;

    win_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            for (int r = 0; r < 3; r++) begin
                st_d.win[r][0] = st_q.win[r][1];
                st_d.win[r][1] = st_q.win[r][2];
            end
            st_d.win[0][2] = tap_top;
            st_d.win[1][2] = tap_mid;
            st_d.win[2][2] = tap_bot;
            st_d.x         = pos_x;
            st_d.y         = pos_y;
            st_d.border    = (pos_x < X_TWO) || (pos_y < Y_TWO);
            if (in_sof) begin
                st_d.frame_thr = in_thr;
                st_d.thr       = in_thr;
            end else begin
                st_d.thr       = st_q.frame_thr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s1_valid  = st_q.valid;
    assign s1_x      = st_q.x;
    assign s1_y      = st_q.y;
    assign s1_border = st_q.border;
    assign s1_thr    = st_q.thr;
    assign s1_win    = st_q.win;

    assert_window_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q.win));

    assert_thr_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sof) |=> (st_q.frame_thr == $past(st_q.frame_thr)));

endmodule

// File: rtl/sobel_gradient.sv
module sobel_gradient
    import sobel_pkg::*;
#(
    parameter int MAX_W = 640,
    parameter int MAX_H = 480
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s1_valid,
    input  logic [$clog2(MAX_W)-1:0] s1_x,
    input  logic [$clog2(MAX_H)-1:0] s1_y,
    input  logic                     s1_border,
    input  mag_t                     s1_thr,
    input  win_t                     s1_win,
    output logic                     s2_valid,
    output logic [$clog2(MAX_W)-1:0] s2_x,
    output logic [$clog2(MAX_H)-1:0] s2_y,
    output logic                     s2_border,
    output mag_t                     s2_thr,
    output grad_t                    s2_gx,
    output grad_t                    s2_gy
);
    localparam int X_W = $clog2(MAX_W);
    localparam int Y_W = $clog2(MAX_H);
    localparam grad_t G_HI = grad_t'(GRAD_MAX);
    localparam grad_t G_LO = -grad_t'(GRAD_MAX);

    typedef struct packed {
        logic           valid;
        logic [X_W-1:0] x;
        logic [Y_W-1:0] y;
        logic           border;
        mag_t           thr;
        grad_t          gx;
        grad_t          gy;
    } grad_st_t;

    grad_st_t st_d, st_q;
    grad_t    axis_sum [2];

    // axis 0: right column minus left column; axis 1: bottom row minus top row.
    // the centre taps carry weight zero and are not read at all
    for (genvar a = 0; a < 2; a++) begin : g_axis
        if (a == 0) begin : g_horiz
            assign axis_sum[a] =
                weigh121(s1_win[0][2], s1_win[1][2], s1_win[2][2]) -
                weigh121(s1_win[0][0], s1_win[1][0], s1_win[2][0]);
        end else begin : g_vert
            assign axis_sum[a] =
                weigh121(s1_win[2][0], s1_win[2][1], s1_win[2][2]) -
                weigh121(s1_win[0][0], s1_win[0][1], s1_win[0][2]);
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.valid  = s1_valid;
        st_d.x      = s1_x;
        st_d.y      = s1_y;
        st_d.border = s1_border;
        st_d.thr    = s1_thr;
        st_d.gx     = axis_sum[0];
        st_d.gy     = axis_sum[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s2_valid  = st_q.valid;
    assign s2_x      = st_q.x;
    assign s2_y      = st_q.y;
    assign s2_border = st_q.border;
    assign s2_thr    = st_q.thr;
    assign s2_gx     = st_q.gx;
    assign s2_gy     = st_q.gy;

    assert_gx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> ((st_q.gx <= G_HI) && (st_q.gx >= G_LO)));

    assert_gy_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> ((st_q.gy <= G_HI) && (st_q.gy >= G_LO)));

endmodule

// File: rtl/sobel_decide.sv
module sobel_decide
    import sobel_pkg::*;
#(
    parameter int MAX_W = 640,
    parameter int MAX_H = 480
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s2_valid,
    input  logic [$clog2(MAX_W)-1:0] s2_x,
    input  logic [$clog2(MAX_H)-1:0] s2_y,
    input  logic                     s2_border,
    input  mag_t                     s2_thr,
    input  grad_t                    s2_gx,
    input  grad_t                    s2_gy,
    output logic                     out_valid,
    output logic                     out_edge,
    output logic [$clog2(MAX_W)-1:0] out_x,
    output logic [$clog2(MAX_H)-1:0] out_y
);
    localparam int X_W = $clog2(MAX_W);
    localparam int Y_W = $clog2(MAX_H);
    localparam mag_t MAG_LIM = mag_t'(2 * GRAD_MAX);
    localparam logic [X_W-1:0] X_TWO = 2;
    localparam logic [Y_W-1:0] Y_TWO = 2;

    typedef struct packed {
        logic           valid;
        logic           edge_bit;
        logic [X_W-1:0] x;
        logic [Y_W-1:0] y;
        mag_t           mag;
    } dec_st_t;

    dec_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.valid    = s2_valid;
        st_d.x        = s2_x;
        st_d.y        = s2_y;
        st_d.mag      = magnitude(s2_gx) + magnitude(s2_gy);
        st_d.edge_bit = s2_valid && !s2_border && (st_d.mag > s2_thr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_edge  = st_q.edge_bit;
    assign out_x     = st_q.x;
    assign out_y     = st_q.y;

    assert_mag_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> (st_q.mag <= MAG_LIM));

    assert_border_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ((out_x < X_TWO) || (out_y < Y_TWO))) |-> !out_edge);

    assert_edge_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_edge |-> out_valid);

endmodule

// File: rtl/sobel_edge_stream.sv
module sobel_edge_stream
    import sobel_pkg::*;
#(
    parameter int MAX_W = 640,
    parameter int MAX_H = 480
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_sof,
    input  logic                     in_eol,
    input  logic [PIX_W-1:0]         in_pix,
    input  logic [MAG_W-1:0]         in_thr,
    output logic                     out_valid,
    output logic                     out_edge,
    output logic [$clog2(MAX_W)-1:0] out_x,
    output logic [$clog2(MAX_H)-1:0] out_y
);
    localparam int X_W = $clog2(MAX_W);
    localparam int Y_W = $clog2(MAX_H);

    pix_t           tap_top, tap_mid;
    logic [X_W-1:0] cur_x, s1_x, s2_x;
    logic [Y_W-1:0] cur_y, s1_y, s2_y;
    logic           s1_valid, s1_border, s2_valid, s2_border;
    mag_t           s1_thr, s2_thr;
    win_t           s1_win;
    grad_t          s2_gx, s2_gy;

    sobel_line_store #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_lines (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eol(in_eol), .in_pix(in_pix), .tap_top(tap_top), .tap_mid(tap_mid),
        .cur_x(cur_x), .cur_y(cur_y)
    );

    sobel_window #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_window (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_thr(in_thr), .tap_top(tap_top), .tap_mid(tap_mid), .tap_bot(in_pix),
        .pos_x(cur_x), .pos_y(cur_y), .s1_valid(s1_valid), .s1_x(s1_x),
        .s1_y(s1_y), .s1_border(s1_border), .s1_thr(s1_thr), .s1_win(s1_win)
    );

    sobel_gradient #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_grad (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_x(s1_x), .s1_y(s1_y),
        .s1_border(s1_border), .s1_thr(s1_thr), .s1_win(s1_win),
        .s2_valid(s2_valid), .s2_x(s2_x), .s2_y(s2_y), .s2_border(s2_border),
        .s2_thr(s2_thr), .s2_gx(s2_gx), .s2_gy(s2_gy)
    );

    sobel_decide #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_decide (
        .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_x(s2_x), .s2_y(s2_y),
        .s2_border(s2_border), .s2_thr(s2_thr), .s2_gx(s2_gx), .s2_gy(s2_gy),
        .out_valid(out_valid), .out_edge(out_edge), .out_x(out_x), .out_y(out_y)
    );

    // cycles since reset, saturating, so the latency check never looks before reset
    logic [1:0] warm_d, warm_q;

    always_comb begin
        warm_d = warm_q;
        if (warm_q != 2'd3) warm_d = warm_q + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) warm_q <= '0;
        else        warm_q <= warm_d;
    end

    assert_pipe_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_reset_quiet_R11: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_edge));

endmodule

// File: tb/sobel_edge_stream_bench.sv
`timescale 1ns/1ps
module sobel_edge_stream_bench;

    localparam int NF = 11;
    localparam int MW = 16;
    localparam int MH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
    logic [7:0] in_pix = '0;
    logic [10:0] in_thr = '0;
    logic       out_valid, out_edge;
    logic [3:0] out_x, out_y;

    sobel_edge_stream #(.MAX_W(MW), .MAX_H(MH)) u_sobel_edge_stream (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eol(in_eol), .in_pix(in_pix), .in_thr(in_thr),
        .out_valid(out_valid), .out_edge(out_edge), .out_x(out_x), .out_y(out_y)
    );

    always #4 clk = ~clk;

    int tests = 0, fails = 0, cyc = 0;
    bit finished = 0;

    logic [7:0] img [NF][8][8];
    int    fw [NF], fh [NF], fthr [NF];
    string ftag [NF];
    logic [31:0] rs = 32'h1234_5678;

    int mf = 0, mx = 0, my = 0;
    int t_first = -1;
    bit seen_first = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            chk(1'b0, "watchdog R1", cyc, 100000);
            finish_run();
        end
    end

    function automatic int expect_edge(input int f, input int x, input int y);
        int gx, gy, m;
        if (x < 2 || y < 2) return 0;
        gx = (int'(img[f][y-2][x]) + 2*int'(img[f][y-1][x]) + int'(img[f][y][x]))
           - (int'(img[f][y-2][x-2]) + 2*int'(img[f][y-1][x-2]) + int'(img[f][y][x-2]));
        gy = (int'(img[f][y][x-2]) + 2*int'(img[f][y][x-1]) + int'(img[f][y][x]))
           - (int'(img[f][y-2][x-2]) + 2*int'(img[f][y-2][x-1]) + int'(img[f][y-2][x]));
        m = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
        return (m > fthr[f]) ? 1 : 0;
    endfunction

    // result monitor: results must arrive in input order (R1, R2)
    always @(negedge clk) begin
        if (rst_n && out_valid && !finished) begin
            if (!seen_first) begin
                seen_first = 1;
                chk((cyc - t_first) == 3, "R1 latency", cyc - t_first, 3);
            end
            if (mf >= NF) begin
                chk(1'b0, "R1 extra result", mf, NF);
            end else begin
                chk((int'(out_x) == mx) && (int'(out_y) == my), "R2 position",
                    int'(out_y) * 100 + int'(out_x), my * 100 + mx);
                chk(int'(out_edge) == expect_edge(mf, mx, my),
                    (mx < 2 || my < 2) ? "R7 border" : ftag[mf],
                    int'(out_edge), expect_edge(mf, mx, my));
                mx++;
                if (mx == fw[mf]) begin
                    mx = 0; my++;
                    if (my == fh[mf]) begin my = 0; mf++; end
                end
            end
        end
    end

    task automatic drive(input logic [7:0] p, input logic sof, input logic eol,
                         input int thr);
        @(negedge clk);
        if (t_first < 0) t_first = cyc;
        in_valid = 1'b1; in_sof = sof; in_eol = eol; in_pix = p;
        in_thr = 11'(thr);
    endtask

    task automatic idle(input int n, input bit probe);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
            if (probe && i == 4) chk(out_valid == 1'b0, "R9 idle no result", int'(out_valid), 0);
        end
    endtask

    function automatic logic [7:0] rnd();
        rs = rs * 32'd1103515245 + 32'd12345;
        return rs[23:16];
    endfunction

    initial begin
        // frame setup
        for (int f = 0; f < NF; f++) begin
            fw[f] = 8; fh[f] = 6; ftag[f] = "R6";
        end
        fthr[0] = 240;  ftag[0] = "R6 equal-threshold ramp R3";
        fthr[1] = 100;  ftag[1] = "R4";
        fthr[2] = 300;  ftag[2] = "R6";
        fthr[3] = 1000; ftag[3] = "R5";
        fthr[4] = 0;    ftag[4] = "R6 zero";
        fthr[5] = 2047; ftag[5] = "R6 max";
        fthr[6] = 200;  ftag[6] = "R10"; fw[6] = 5; fh[6] = 7;
        fthr[7] = 250;  ftag[7] = "R8";
        fthr[8] = 300;  ftag[8] = "R9";
        fthr[9] = 1500; ftag[9] = "R6 checker";
        fthr[10] = 239; ftag[10] = "R3";
        for (int f = 0; f < NF; f++)
            for (int y = 0; y < 8; y++)
                for (int x = 0; x < 8; x++) begin
                    case (f)
                        0, 10: img[f][y][x] = 8'(x * 30);
                        1:     img[f][y][x] = 8'(y * 40);
                        3:     img[f][y][x] = (x >= 4 && y >= 3) ? 8'd255 : 8'd0;
                        9:     img[f][y][x] = ((x + y) % 2 == 1) ? 8'd255 : 8'd0;
                        default: img[f][y][x] = rnd();
                    endcase
                end

        // reset state (R11)
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R11 reset valid", int'(out_valid), 0);
        chk(out_edge == 1'b0, "R11 reset edge", int'(out_edge), 0);
        rst_n = 1'b1;
        idle(2, 0);
        chk(out_valid == 1'b0, "R11 idle after reset", int'(out_valid), 0);

        for (int f = 0; f < NF; f++) begin
            for (int y = 0; y < fh[f]; y++)
                for (int x = 0; x < fw[f]; x++) begin
                    int thr;
                    thr = fthr[f];
                    if (f == 7 && !(x == 0 && y == 0)) thr = 0; // R8: late change ignored
                    drive(img[f][y][x], (x == 0 && y == 0), (x == fw[f] - 1), thr);
                    if (f == 8) begin
                        if (x == fw[f] - 1) idle(5, 1);
                        else                idle(1, 0);
                    end
                end
        end
        idle(10, 0);
        chk(mf == NF, "R1 result count", mf, NF);
        chk(out_valid == 1'b0, "R9 quiet at end", int'(out_valid), 0);
        finish_run();
    end

endmodule